// File: doc/BRIEF.md
# Qualified Pulse Peak Detector

This block sits behind the digitiser of a radiation detector. It takes one signed sample per clock and removes the baseline level from each sample. The baseline is either a fixed offset supplied by configuration or an estimate that a slow first-order average keeps up to date. The corrected stream can pass through a moving-average smoother of 2, 4, 8 or 16 taps, or it can bypass the smoother. A pulse tracker then watches the result. It measures the height and length of every excursion above a threshold.

An excursion is reported only if it passes a set of tests. Its peak must reach a programmable floor, and its length must lie inside a programmable window, so noise spikes and stuck levels are not reported. A second pulse that rides on the tail of the first shows up as a renewed rise after a dip. Such pulses are marked as pileup, or dropped when rejection is enabled. Each accepted pulse yields a single one-cycle strobe that carries the peak, the width and the pileup mark. Downstream energy binning uses this output.

Top module: `pulse_peak_qual`

## Requirements
- R1: While reset is held and until the first pulse is reported, `pk_vld`, `pk_amp`, `pk_pileup` and `pk_width` are all zero.
- R2: With `bl_auto` low, each sample has `bl_ofs` subtracted before any further processing, so a reported peak is the raw peak minus `bl_ofs`.
- R3: With `bl_auto` high, the baseline is `acc >>> 4`. The register `acc` starts at zero and adds `sample - (acc >>> 4)` on every clock, whatever mode is selected. The baseline is read before that clock's update.
- R4: With `ma_en` high, the detector sees the arithmetic-shift floor of the mean of the last L corrected samples, where L = 2, 4, 8, 16 for `ma_len` = 0, 1, 2, 3. With `ma_en` low, it sees the corrected sample, one clock later.
- R5: In any clock where `ma_len` differs from its value at the previous clock, the smoother history is cleared and its output for that clock is zero.
- R6: A pulse begins at the first smoothed sample at or above `thr` and ends at the first one below `thr`. Its width is the number of samples at or above `thr`, and its peak is the largest of them. The report strobe rises three clocks after the raw sample that ended the pulse entered.
- R7: A pulse whose peak is below `pk_floor` is not reported.
- R8: A pulse is reported only if `wid_min <= width <= wid_max`. The width counter saturates at 255.
- R9: Within a pulse, the pileup mark is set when the signal, after it has fallen below the running peak, exceeds the lowest value seen since that peak by more than `hyst`.
- R10: With `pu_reject` high, marked pulses are dropped, and unmarked pulses are still reported.
- R11: A new pulse may begin on the sample right after the sample that ended the previous one.
- R12: `pk_vld` is high for one clock per reported pulse. `pk_amp`, `pk_pileup` and `pk_width` change only when `pk_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_in | input | W | Signed raw sample |
| bl_auto | input | 1 | 1 selects the tracked baseline, 0 selects `bl_ofs` |
| bl_ofs | input | W | Signed fixed baseline offset |
| ma_en | input | 1 | Enables the moving-average smoother |
| ma_len | input | 2 | Smoother length code: 0=2, 1=4, 2=8, 3=16 taps |
| thr | input | W+1 | Signed start/end threshold |
| pk_floor | input | W+1 | Signed minimum reportable peak |
| hyst | input | W | Unsigned re-rise margin for pileup |
| wid_min | input | 8 | Minimum accepted width in samples |
| wid_max | input | 8 | Maximum accepted width in samples |
| pu_reject | input | 1 | 1 drops pileup-marked pulses |
| pk_vld | output | 1 | One-clock report strobe |
| pk_amp | output | W+1 | Signed peak of the reported pulse |
| pk_pileup | output | 1 | Pileup mark of the reported pulse |
| pk_width | output | 8 | Width of the reported pulse in samples |

## Verification
The bench targets the following corner cases:
- **Dip and re-rise:** a dip followed by a re-rise just under and just over the hysteresis. A wrong margin compare marks clean pulses or passes real pileup.
- **Glitches and long runs:** single-sample glitches and over-long runs. A missing width bound reports both.
- **Peak floor:** pulses that cross the threshold but stay below the peak floor.
- **Back-to-back pulses:** pulses with one sub-threshold sample between them. A tracker that needs an idle cycle merges or loses them.
- **Length change:** a change of smoother length while a pulse is high, where a missing history clear yields one merged pulse instead of two.
- **Width saturation:** a 300-sample run, where a counter that wraps reports a small width.
- **Random stream:** a dense random stream with overlapping pulses, compared every clock against a behavioural model.

// File: rtl/pkq_pkg.sv
package pkq_pkg;

  // tracker state
  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_LIVE = 1'b1
  } trk_state_e;

  // smoother length code width; lengths are 2 << code
  localparam int unsigned MA_SEL_W = 2;
  localparam int unsigned MA_TAPS  = 2 << ((1 << MA_SEL_W) - 1);

endpackage

// File: rtl/pkq_baseline.sv
module pkq_baseline #(
  parameter int unsigned W   = 12,
  parameter int unsigned BLS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] x,
  input  logic                auto_en,
  input  logic signed [W-1:0] ofs,
  output logic signed [W:0]   cor
);

  localparam int unsigned AW = W + BLS + 1;

  logic signed [AW-1:0] acc_q, acc_d, x_ext;
  logic signed [W:0]    base, cor_d, cor_q;

  // next state
  always_comb begin
    x_ext = {{(BLS + 1){x[W-1]}}, x};
    acc_d = acc_q + x_ext - (acc_q >>> BLS);
    if (auto_en) base = acc_q[W+BLS:BLS];
    else         base = {ofs[W-1], ofs};
    cor_d = {x[W-1], x} - base;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cor_q <= '0;
    end else begin
      acc_q <= acc_d;
      cor_q <= cor_d;
    end
  end

  assign cor = cor_q;

endmodule

// File: rtl/pkq_smooth.sv
module pkq_smooth
  import pkq_pkg::*;
#(
  parameter int unsigned DW = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [DW-1:0] din,
  input  logic                en,
  input  logic [MA_SEL_W-1:0] len_sel,
  output logic signed [DW-1:0] dout
);

  localparam int unsigned TAPS = MA_TAPS;
  localparam int unsigned SW   = DW + $clog2(TAPS);
  localparam int unsigned NSEL = 1 << MA_SEL_W;

  logic signed [DW-1:0] tap_q [TAPS];
  logic signed [DW-1:0] tap_d [TAPS];
  logic signed [SW-1:0] sum_q, sum_d, din_x, tail_x;
  logic signed [DW-1:0] tail, dout_d, dout_q;
  logic [MA_SEL_W-1:0]  len_q;
  logic                 clr;

  // next state
  always_comb begin
    clr  = (len_sel != len_q);
    tail = '0;
    for (int k = 0; k < int'(NSEL); k++) begin
      if (len_sel == MA_SEL_W'(k)) tail = tap_q[(2 << k) - 1];
    end
    din_x  = {{(SW - DW){din[DW-1]}}, din};
    tail_x = {{(SW - DW){tail[DW-1]}}, tail};
    sum_d  = sum_q + din_x - tail_x;
    dout_d = din;
    if (en) begin
      for (int k = 0; k < int'(NSEL); k++) begin
        if (len_sel == MA_SEL_W'(k)) dout_d = DW'(sum_d >>> (k + 1));
      end
    end
    tap_d[0] = din;
    for (int k = 1; k < int'(TAPS); k++) tap_d[k] = tap_q[k-1];
    if (clr) begin
      sum_d  = '0;
      dout_d = '0;
      for (int k = 0; k < int'(TAPS); k++) tap_d[k] = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      dout_q <= '0;
      len_q  <= '0;
      for (int k = 0; k < int'(TAPS); k++) tap_q[k] <= '0;
    end else begin
      sum_q  <= sum_d;
      dout_q <= dout_d;
      len_q  <= len_sel;
      for (int k = 0; k < int'(TAPS); k++) tap_q[k] <= tap_d[k];
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/pkq_tracker.sv
module pkq_tracker
  import pkq_pkg::*;
#(
  parameter int unsigned DW = 13,
  parameter int unsigned HW = 12,
  parameter int unsigned CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] f,
  input  logic signed [DW-1:0] thr,
  input  logic signed [DW-1:0] pk_min,
  input  logic [HW-1:0]        hyst,
  input  logic [CW-1:0]        wmin,
  input  logic [CW-1:0]        wmax,
  input  logic                 rej,
  output logic                 vld,
  output logic signed [DW-1:0] amp,
  output logic                 pu,
  output logic [CW-1:0]        wid
);

  trk_state_e           st_q, st_d;
  logic signed [DW-1:0] pk_q, pk_d, lo_q, lo_d, amp_q;
  logic [CW-1:0]        w_q, w_d, w_inc, wid_q;
  logic                 pu_q, pu_d, pux_q;
  logic                 vld_d, vld_q, load;
  logic                 above, bump, qual;
  logic signed [DW:0]   rise, hyst_x;

  // next state
  always_comb begin
    above  = (f >= thr);
    rise   = {f[DW-1], f} - {lo_q[DW-1], lo_q};
    hyst_x = {{(DW + 1 - HW){1'b0}}, hyst};
    bump   = (lo_q < pk_q) && (rise > hyst_x);
    w_inc  = (&w_q) ? w_q : w_q + 1'b1;
    qual   = (pk_q >= pk_min) && (w_q >= wmin) && (w_q <= wmax) && !(pu_q && rej);
    st_d   = st_q;
    pk_d   = pk_q;
    lo_d   = lo_q;
    w_d    = w_q;
    pu_d   = pu_q;
    vld_d  = 1'b0;
    load   = 1'b0;
    case (st_q)
      TRK_IDLE: begin
        if (above) begin
          st_d = TRK_LIVE;
          pk_d = f;
          lo_d = f;
          w_d  = CW'(1);
          pu_d = 1'b0;
        end
      end
      TRK_LIVE: begin
        if (above) begin
          w_d = w_inc;
          if (bump) pu_d = 1'b1;
          if (f > pk_q) begin
            pk_d = f;
            lo_d = f;
          end else if (f < lo_q) begin
            lo_d = f;
          end
        end else begin
          st_d = TRK_IDLE;
          if (qual) begin
            vld_d = 1'b1;
            load  = 1'b1;
          end
        end
      end
      default: st_d = TRK_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRK_IDLE;
      pk_q  <= '0;
      lo_q  <= '0;
      w_q   <= '0;
      pu_q  <= 1'b0;
      vld_q <= 1'b0;
      amp_q <= '0;
      pux_q <= 1'b0;
      wid_q <= '0;
    end else begin
      st_q  <= st_d;
      pk_q  <= pk_d;
      lo_q  <= lo_d;
      w_q   <= w_d;
      pu_q  <= pu_d;
      vld_q <= vld_d;
      if (load) begin
        amp_q <= pk_q;
        pux_q <= pu_q;
        wid_q <= w_q;
      end
    end
  end

  assign vld = vld_q;
  assign amp = amp_q;
  assign pu  = pux_q;
  assign wid = wid_q;

endmodule

// File: rtl/pulse_peak_qual.sv
module pulse_peak_qual
  import pkq_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned BL_SHIFT = 4,
  parameter int unsigned CW       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] adc_in,
  input  logic                bl_auto,
  input  logic signed [W-1:0] bl_ofs,
  input  logic                ma_en,
  input  logic [1:0]          ma_len,
  input  logic signed [W:0]   thr,
  input  logic signed [W:0]   pk_floor,
  input  logic [W-1:0]        hyst,
  input  logic [CW-1:0]       wid_min,
  input  logic [CW-1:0]       wid_max,
  input  logic                pu_reject,
  output logic                pk_vld,
  output logic signed [W:0]   pk_amp,
  output logic                pk_pileup,
  output logic [CW-1:0]       pk_width
);

  localparam int unsigned DW = W + 1;

  logic [1:0]           rs_q;
  logic                 rst_i_n;
  logic signed [DW-1:0] cor, filt;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  pkq_baseline #(.W(W), .BLS(BL_SHIFT)) u_base (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .x       (adc_in),
    .auto_en (bl_auto),
    .ofs     (bl_ofs),
    .cor     (cor)
  );

  pkq_smooth #(.DW(DW)) u_smooth (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .din     (cor),
    .en      (ma_en),
    .len_sel (ma_len),
    .dout    (filt)
  );

  pkq_tracker #(.DW(DW), .HW(W), .CW(CW)) u_trk (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .f      (filt),
    .thr    (thr),
    .pk_min (pk_floor),
    .hyst   (hyst),
    .wmin   (wid_min),
    .wmax   (wid_max),
    .rej    (pu_reject),
    .vld    (pk_vld),
    .amp    (pk_amp),
    .pu     (pk_pileup),
    .wid    (pk_width)
  );

endmodule

// File: rtl/pkq_checker.sv
module pkq_checker #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic signed [W:0]   thr,
  input logic signed [W:0]   pk_floor,
  input logic [CW-1:0]       wid_min,
  input logic [CW-1:0]       wid_max,
  input logic                pu_reject,
  input logic                pk_vld,
  input logic signed [W:0]   pk_amp,
  input logic                pk_pileup,
  input logic [CW-1:0]       pk_width
);

  // R6: a reported peak never lies below the threshold that opened the pulse
  p_amp_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |-> (pk_amp >= $past(thr)));

  // R7: a reported peak meets the floor
  p_amp_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |-> (pk_amp >= $past(pk_floor)));

  // R8: reported width inside the window
  p_width_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |-> ((pk_width >= $past(wid_min)) && (pk_width <= $past(wid_max))));

  // R10: no marked pulse escapes while rejection is on
  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_vld && $past(pu_reject)) |-> !pk_pileup);

  // R12: single-cycle strobe
  p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |=> !pk_vld);

  // R12: report fields hold between strobes
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_vld |-> ($stable(pk_amp) && $stable(pk_width) && $stable(pk_pileup)));

endmodule

bind pulse_peak_qual pkq_checker #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .thr       (thr),
  .pk_floor  (pk_floor),
  .wid_min   (wid_min),
  .wid_max   (wid_max),
  .pu_reject (pu_reject),
  .pk_vld    (pk_vld),
  .pk_amp    (pk_amp),
  .pk_pileup (pk_pileup),
  .pk_width  (pk_width)
);

// File: tb/sim_pulse_peak_qual.sv
module sim_pulse_peak_qual;

  localparam int W = 12;

  logic                clk = 1'b0;
  logic                rst_n;
  logic signed [W-1:0] adc_in;
  logic                bl_auto;
  logic signed [W-1:0] bl_ofs;
  logic                ma_en;
  logic [1:0]          ma_len;
  logic signed [W:0]   thr;
  logic signed [W:0]   pk_floor;
  logic [W-1:0]        hyst;
  logic [7:0]          wid_min;
  logic [7:0]          wid_max;
  logic                pu_reject;
  logic                pk_vld;
  logic signed [W:0]   pk_amp;
  logic                pk_pileup;
  logic [7:0]          pk_width;

  always #5 clk = ~clk;

  pulse_peak_qual u0 (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .bl_auto(bl_auto), .bl_ofs(bl_ofs),
    .ma_en(ma_en), .ma_len(ma_len), .thr(thr), .pk_floor(pk_floor), .hyst(hyst),
    .wid_min(wid_min), .wid_max(wid_max), .pu_reject(pu_reject),
    .pk_vld(pk_vld), .pk_amp(pk_amp), .pk_pileup(pk_pileup), .pk_width(pk_width)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference
  int mr1 = 0, mr2 = 0;
  int m_acc = 0, m_s1 = 0, m_filt = 0, m_lenq = 0;
  int hist[$];
  int m_act = 0, m_pk = 0, m_lo = 0, m_w = 0, m_pu = 0;
  int m_vld = 0, m_amp = 0, m_puo = 0, m_wo = 0;

  task automatic m_clear();
    m_acc = 0; m_s1 = 0; m_filt = 0; m_lenq = 0;
    hist.delete();
    for (int k = 0; k < 16; k++) hist.push_back(0);
    m_act = 0; m_pk = 0; m_lo = 0; m_w = 0; m_pu = 0;
    m_vld = 0; m_amp = 0; m_puo = 0; m_wo = 0;
  endtask

  task automatic m_step();
    int f, base, sum, len;
    f = m_filt;
    m_vld = 0;
    if (m_act == 0) begin
      if (f >= int'(thr)) begin
        m_act = 1; m_pk = f; m_lo = f; m_w = 1; m_pu = 0;
      end
    end else if (f >= int'(thr)) begin
      if (m_w < 255) m_w++;
      if (m_lo < m_pk && (f - m_lo) > int'(hyst)) m_pu = 1;
      if (f > m_pk) begin m_pk = f; m_lo = f; end
      else if (f < m_lo) m_lo = f;
    end else begin
      m_act = 0;
      if (m_pk >= int'(pk_floor) && m_w >= int'(wid_min) && m_w <= int'(wid_max)
          && !(m_pu == 1 && pu_reject)) begin
        m_vld = 1; m_amp = m_pk; m_puo = m_pu; m_wo = m_w;
      end
    end
    if (int'(ma_len) != m_lenq) begin
      for (int k = 0; k < 16; k++) hist[k] = 0;
      m_filt = 0;
      m_lenq = int'(ma_len);
    end else begin
      hist.push_front(m_s1);
      void'(hist.pop_back());
      len = 2 << ma_len;
      sum = 0;
      for (int k = 0; k < len; k++) sum += hist[k];
      m_filt = ma_en ? (sum >>> (int'(ma_len) + 1)) : m_s1;
    end
    base = bl_auto ? (m_acc >>> 4) : int'(bl_ofs);
    m_s1 = int'(adc_in) - base;
    m_acc = m_acc + int'(adc_in) - (m_acc >>> 4);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; m_clear();
    end else begin
      if (mr2 == 0) m_clear(); else m_step();
      mr2 = mr1; mr1 = 1;
    end
  end

  // per-clock comparison and report capture
  int rep_cnt = 0, last_amp = 0, last_w = 0, last_pu = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      n_chk++;
      if (int'(pk_vld) != m_vld || int'(pk_amp) != m_amp || int'(pk_pileup) != m_puo
          || int'(pk_width) != m_wo) begin
        n_bad++;
        $display("FAIL %s: vld/amp/pu/wid actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 cur_req, pk_vld, pk_amp, pk_pileup, pk_width, m_vld, m_amp, m_puo, m_wo);
      end
      if (pk_vld) begin
        rep_cnt++; last_amp = int'(pk_amp); last_w = int'(pk_width); last_pu = int'(pk_pileup);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic feed(int v);
    @(negedge clk);
    adc_in = W'(v);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) feed(100);
  endtask

  task automatic feed_corr(int v); // value relative to a fixed offset of 100
    feed(100 + v);
  endtask

  task automatic defaults();
    bl_auto = 0; bl_ofs = 100; ma_en = 0; ma_len = 0;
    thr = 50; pk_floor = 80; hyst = 20; wid_min = 2; wid_max = 20; pu_reject = 0;
  endtask

  int sbuf[3000];

  task automatic rand_run(int seed);
    int t, h, r, fl;
    void'($urandom(seed));
    for (int k = 0; k < 3000; k++) sbuf[k] = 100 + $urandom_range(0, 6) - 3;
    t = 20;
    while (t < 2900) begin
      h = $urandom_range(60, 600); r = $urandom_range(1, 3); fl = $urandom_range(2, 5);
      for (int k = 0; k < r; k++) sbuf[t + k] += (h * (k + 1)) / r;
      for (int k = 0; k < fl; k++) sbuf[t + r + k] += (h * (fl - k - 1)) / fl;
      t += $urandom_range(3, 12);
    end
    for (int k = 0; k < 3000; k++) begin
      if (sbuf[k] > 2047) sbuf[k] = 2047;
      feed(sbuf[k]);
    end
    idle(30);
  endtask

  initial begin
    rst_n = 1'b0;
    adc_in = 100;
    defaults();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pk_vld in reset", int'(pk_vld), 0);
    chk("R1", "pk_amp in reset", int'(pk_amp), 0);
    chk("R1", "pk_width in reset", int'(pk_width), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(6);
    chk("R1", "pk_vld after release", int'(pk_vld), 0);
    chk("R1", "pk_pileup after release", int'(pk_pileup), 0);

    // R2 / R6: clean pulse with fixed offset, latency of three clocks
    cur_req = "R2"; rep_cnt = 0;
    feed_corr(100); feed_corr(200); feed_corr(150); feed_corr(20);
    feed(100); feed(100);
    chk("R6", "strobe before latency", int'(pk_vld), 0);
    @(negedge clk);
    chk("R6", "strobe at latency", int'(pk_vld), 1);
    idle(8);
    chk("R2", "clean count", rep_cnt, 1);
    chk("R2", "peak minus offset", last_amp, 200);
    chk("R6", "width", last_w, 3);

    // R7: below floor
    cur_req = "R7"; rep_cnt = 0;
    feed_corr(60); feed_corr(70); feed_corr(60); idle(10);
    chk("R7", "sub-floor count", rep_cnt, 0);

    // R8: glitch and over-long run
    cur_req = "R8"; rep_cnt = 0;
    feed_corr(200); idle(8);
    for (int k = 0; k < 25; k++) feed_corr(200);
    idle(10);
    chk("R8", "glitch/long count", rep_cnt, 0);

    // R9: pileup above and below margin
    cur_req = "R9"; rep_cnt = 0;
    feed_corr(100); feed_corr(200); feed_corr(120); feed_corr(180); feed_corr(100); idle(10);
    chk("R9", "pileup count", rep_cnt, 1);
    chk("R9", "pileup mark", last_pu, 1);
    chk("R9", "pileup width", last_w, 5);
    feed_corr(100); feed_corr(200); feed_corr(150); feed_corr(160); feed_corr(100); idle(10);
    chk("R9", "small bump mark", last_pu, 0);

    // R10: rejection
    cur_req = "R10"; pu_reject = 1; rep_cnt = 0;
    feed_corr(100); feed_corr(200); feed_corr(120); feed_corr(180); feed_corr(100); idle(10);
    chk("R10", "rejected count", rep_cnt, 0);
    feed_corr(100); feed_corr(200); feed_corr(100); idle(10);
    chk("R10", "clean kept", rep_cnt, 1);
    pu_reject = 0;

    // R11: back-to-back one-sample pulses
    cur_req = "R11"; wid_min = 1; rep_cnt = 0;
    for (int k = 0; k < 4; k++) begin feed_corr(200); feed_corr(0); end
    idle(10);
    chk("R11", "back-to-back count", rep_cnt, 4);
    chk("R11", "one-sample width", last_w, 1);
    wid_min = 2;

    // R4: smoothing lengths
    cur_req = "R4"; ma_en = 1; ma_len = 1; idle(20); rep_cnt = 0;
    for (int k = 0; k < 4; k++) feed_corr(200);
    idle(15);
    chk("R4", "L4 count", rep_cnt, 1);
    chk("R4", "L4 peak", last_amp, 200);
    chk("R4", "L4 width", last_w, 7);
    for (int s = 0; s < 4; s++) begin
      ma_len = 2'(s); idle(20);
      feed_corr(300); feed_corr(500); feed_corr(250); feed_corr(100); idle(20);
    end

    // R5: length change mid-pulse clears history
    cur_req = "R5"; wid_max = 255; ma_len = 3; idle(20); rep_cnt = 0;
    for (int k = 0; k < 30; k++) feed_corr(160);
    @(negedge clk); ma_len = 0; adc_in = 260;
    for (int k = 0; k < 10; k++) feed_corr(160);
    idle(20);
    chk("R5", "split count", rep_cnt, 2);
    chk("R5", "second peak", last_amp, 160);
    ma_en = 0; wid_max = 20;

    // R3: tracked baseline
    cur_req = "R3"; bl_auto = 1;
    for (int k = 0; k < 250; k++) feed(500);
    rep_cnt = 0;
    feed(700); feed(800); feed(700);
    for (int k = 0; k < 10; k++) feed(500);
    chk("R3", "auto count", rep_cnt, 1);
    chk("R3", "auto peak", last_amp, 288);
    chk("R3", "auto width", last_w, 3);
    bl_auto = 0; idle(10);

    // R8: width saturation
    cur_req = "R8"; wid_min = 1; wid_max = 255; rep_cnt = 0;
    for (int k = 0; k < 300; k++) feed_corr(200);
    idle(10);
    chk("R8", "saturated count", rep_cnt, 1);
    chk("R8", "saturated width", last_w, 255);
    defaults(); idle(10);

    // R12: dense random stream with overlap
    cur_req = "R12"; thr = 40; pk_floor = 60; hyst = 15; wid_max = 12;
    rand_run(7);
    cur_req = "R12"; ma_en = 1; idle(20); pu_reject = 1;
    rand_run(11);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule